// File: doc/BRIEF.md
# Card memory byte-lane access controller

This block sits between a host with a 16-bit memory-card bus and the card's internal memory. From the two active-low card enables, the low address bit, the space select, and the read and write strobes, it picks one of two targets. The first is common memory, built from external devices on a 16-bit internal bus. The second is a 256-byte attribute store held inside the block. For common memory it produces a separate output-enable strobe and a separate write-enable strobe for each internal byte lane. It also steers bytes between the host bus and the internal bus, and swaps lanes for 8-bit host transfers that target an odd address.

The attribute store is reached only through even addresses of a 512-byte window, and only on the low host lane. Its writes are committed by a two-state machine so that each host write strobe stores exactly one byte. In state ST_IDLE, a permitted attribute write commits the byte and moves to ST_HOLD (transition COMMIT). ST_HOLD stays put while that write request remains asserted and returns to ST_IDLE when it drops (transition RELEASE). A write-protect input stops every internal write strobe and every attribute commit, and leaves reads alone. The upper address bits pass straight through to the external devices.

Top module: `card_lane_ctrl`

## Requirements
- R1: After reset, every attribute byte reads as 0x00 and the commit machine is in ST_IDLE.
- R2: Common space (reg_n=1), enables ce1_n=0, ce2_n=1 with host_addr[0]=0 is an even-byte access. A read lowers ext_oe_lo_n and returns id_in[7:0] on hd_out[7:0] with hd_drv_lo=1. A write lowers ext_we_lo_n and puts hd_in[7:0] on id_out[7:0] with id_drv_lo=1.
- R3: The same enables with host_addr[0]=1 swap lanes. A read lowers ext_oe_hi_n and returns id_in[15:8] on hd_out[7:0]. A write lowers ext_we_hi_n and puts hd_in[7:0] on id_out[15:8].
- R4: ce1_n=1, ce2_n=0 is an odd-only access with no swap. It uses the high strobes, and hd_out[15:8]/id_out[15:8] carry the data with the high-lane drive flag set.
- R5: ce1_n=0, ce2_n=0 is a word access. Both lane strobes of the active kind go low, and all 16 bits move with both drive flags set.
- R6: With both enables high, or with neither oe_n nor we_n low, all four strobes stay high, all drive flags are 0 and both data outputs are zero.
- R7: An attribute write (reg_n=0, even access) stores hd_in[7:0] at index host_addr[8:1] once per write strobe. Data changes while the strobe is still held do not alter the stored byte.
- R8: An attribute read returns the stored byte on hd_out[7:0] with hd_drv_lo=1, hd_drv_hi=0 and hd_out[15:8]=0, and it raises no external strobe.
- R9: With reg_n=0, word, odd-only and odd-address accesses are unsupported. They raise no strobe, drive neither bus, and leave the attribute store unchanged.
- R10: With wp=1, ext_we_hi_n and ext_we_lo_n stay high and no attribute byte is committed. Reads of both spaces are unaffected.
- R11: ext_addr always equals host_addr[24:9].
- R12: When we_n and oe_n are both low, the access is a write: no output-enable strobe goes low and the host bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the attribute commit machine |
| rst_n | input | 1 | Active-low reset |
| ce1_n | input | 1 | Card enable, low-lane side, active low |
| ce2_n | input | 1 | Card enable, high-lane side, active low |
| reg_n | input | 1 | Space select: 1 common, 0 attribute |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| wp | input | 1 | Write protect, active high |
| host_addr | input | 25 | Host byte address |
| hd_in | input | 16 | Host write data |
| hd_out | output | 16 | Host read data, zero on undriven lanes |
| hd_drv_hi | output | 1 | Drive host lane [15:8] |
| hd_drv_lo | output | 1 | Drive host lane [7:0] |
| id_in | input | 16 | Read data from external devices |
| id_out | output | 16 | Write data to external devices, zero on undriven lanes |
| id_drv_hi | output | 1 | Drive internal lane [15:8] |
| id_drv_lo | output | 1 | Drive internal lane [7:0] |
| ext_addr | output | 16 | Upper address to external devices |
| ext_oe_hi_n | output | 1 | High-lane output enable, active low |
| ext_oe_lo_n | output | 1 | Low-lane output enable, active low |
| ext_we_hi_n | output | 1 | High-lane write enable, active low |
| ext_we_lo_n | output | 1 | Low-lane write enable, active low |

## Verification
The assertions check on every cycle the properties that hold at all times: write protect keeps both write strobes high and blocks a commit from ST_IDLE, an idle card is fully quiet, attribute space never raises an external strobe, the host and internal buses are never driven together, and a byte committed on entry to ST_HOLD is what reads back and stays put. Only the bench scenarios can show that the right data lands on the right lane for each enable and A0 combination, that an attribute byte lands at the index taken from host_addr[8:1], that unsupported attribute accesses leave the store intact, and that the upper address passes through.

// File: rtl/card_lane_pkg.sv
package card_lane_pkg;

    // Kind of host access, decoded from the two enables and address bit 0
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_EVEN,
        ACC_ODD_SWAP,
        ACC_ODD_ONLY,
        ACC_WORD
    } acc_kind_e;

    // Attribute commit machine
    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } wr_state_e;

endpackage

// File: rtl/card_access_decode.sv
module card_access_decode
    import card_lane_pkg::*;
(
    input  logic      ce1_n,
    input  logic      ce2_n,
    input  logic      a0,
    input  logic      oe_n,
    input  logic      we_n,
    output acc_kind_e kind,
    output logic      rd_req,
    output logic      wr_req
);

    always_comb begin
        unique case ({ce1_n, ce2_n})
            2'b01:   kind = a0 ? ACC_ODD_SWAP : ACC_EVEN;
            2'b10:   kind = ACC_ODD_ONLY;
            2'b00:   kind = ACC_WORD;
            default: kind = ACC_IDLE;
        endcase
    end

    // A write strobe wins over a simultaneous output enable
    always_comb begin
        wr_req = (kind != ACC_IDLE) && !we_n;
        rd_req = (kind != ACC_IDLE) && !oe_n && we_n;
    end

endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
    import card_lane_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int BUS_W = 2 * LANE_W
) (
    input  acc_kind_e         kind,
    input  logic              common_sel,
    input  logic              attr_ok,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              wp,
    input  logic [BUS_W-1:0]  hd_in,
    input  logic [BUS_W-1:0]  id_in,
    input  logic [LANE_W-1:0] attr_rd,
    output logic [BUS_W-1:0]  hd_out,
    output logic              hd_drv_hi,
    output logic              hd_drv_lo,
    output logic [BUS_W-1:0]  id_out,
    output logic              id_drv_hi,
    output logic              id_drv_lo,
    output logic              ext_oe_hi_n,
    output logic              ext_oe_lo_n,
    output logic              ext_we_hi_n,
    output logic              ext_we_lo_n
);

    logic [LANE_W-1:0] hd_lo, hd_hi, id_lo, id_hi;

    assign hd_lo = hd_in[LANE_W-1:0];
    assign hd_hi = hd_in[BUS_W-1:LANE_W];
    assign id_lo = id_in[LANE_W-1:0];
    assign id_hi = id_in[BUS_W-1:LANE_W];

    always_comb begin
        hd_out      = '0;
        hd_drv_hi   = 1'b0;
        hd_drv_lo   = 1'b0;
        id_out      = '0;
        id_drv_hi   = 1'b0;
        id_drv_lo   = 1'b0;
        ext_oe_hi_n = 1'b1;
        ext_oe_lo_n = 1'b1;
        ext_we_hi_n = 1'b1;
        ext_we_lo_n = 1'b1;
        if (common_sel) begin
            unique case (kind)
                ACC_EVEN: begin
                    if (rd_req) begin
                        ext_oe_lo_n           = 1'b0;
                        hd_out[LANE_W-1:0]    = id_lo;
                        hd_drv_lo             = 1'b1;
                    end
                    if (wr_req) begin
                        ext_we_lo_n           = wp;
                        id_out[LANE_W-1:0]    = hd_lo;
                        id_drv_lo             = 1'b1;
                    end
                end
                ACC_ODD_SWAP: begin
                    if (rd_req) begin
                        ext_oe_hi_n           = 1'b0;
                        hd_out[LANE_W-1:0]    = id_hi;
                        hd_drv_lo             = 1'b1;
                    end
                    if (wr_req) begin
                        ext_we_hi_n           = wp;
                        id_out[BUS_W-1:LANE_W] = hd_lo;
                        id_drv_hi             = 1'b1;
                    end
                end
                ACC_ODD_ONLY: begin
                    if (rd_req) begin
                        ext_oe_hi_n            = 1'b0;
                        hd_out[BUS_W-1:LANE_W] = id_hi;
                        hd_drv_hi              = 1'b1;
                    end
                    if (wr_req) begin
                        ext_we_hi_n            = wp;
                        id_out[BUS_W-1:LANE_W] = hd_hi;
                        id_drv_hi              = 1'b1;
                    end
                end
                ACC_WORD: begin
                    if (rd_req) begin
                        ext_oe_hi_n = 1'b0;
                        ext_oe_lo_n = 1'b0;
                        hd_out      = id_in;
                        hd_drv_hi   = 1'b1;
                        hd_drv_lo   = 1'b1;
                    end
                    if (wr_req) begin
                        ext_we_hi_n = wp;
                        ext_we_lo_n = wp;
                        id_out      = hd_in;
                        id_drv_hi   = 1'b1;
                        id_drv_lo   = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (attr_ok && rd_req) begin
            hd_out[LANE_W-1:0] = attr_rd;
            hd_drv_lo          = 1'b1;
        end
    end

endmodule

// File: rtl/card_attr_store.sv
module card_attr_store
    import card_lane_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANE_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_any,
    input  logic              wp,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rd_data
);

    wr_state_e         state, state_nx;
    logic              commit;
    logic [LANE_W-1:0] mem [DEPTH];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and commit output
    always_comb begin
        state_nx = state;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_any && !wp) begin
                    commit   = 1'b1;
                    state_nx = ST_HOLD;    // COMMIT
                end
            end
            ST_HOLD: begin
                if (!wr_any) state_nx = ST_IDLE;  // RELEASE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            mem[idx] <= wdata;
        end
    end

    assign rd_data = mem[idx];

    // R10
    wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && state == ST_IDLE) |=> (state == ST_IDLE));

    // R7
    commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state == ST_HOLD) && $stable(idx)) |-> (rd_data == $past(wdata)));

    // R7
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state == ST_HOLD) && $stable(idx)) |-> $stable(rd_data));

endmodule

// File: rtl/card_lane_ctrl.sv
module card_lane_ctrl
    import card_lane_pkg::*;
#(
    parameter int ADDR_W     = 25,
    parameter int DATA_W     = 16,
    parameter int ATTR_DEPTH = 256,
    localparam int LANE_W    = DATA_W / 2,
    localparam int IDX_W     = $clog2(ATTR_DEPTH),
    localparam int WIN_W     = IDX_W + 1,
    localparam int UP_W      = ADDR_W - WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] hd_in,
    output logic [DATA_W-1:0] hd_out,
    output logic              hd_drv_hi,
    output logic              hd_drv_lo,
    input  logic [DATA_W-1:0] id_in,
    output logic [DATA_W-1:0] id_out,
    output logic              id_drv_hi,
    output logic              id_drv_lo,
    output logic [UP_W-1:0]   ext_addr,
    output logic              ext_oe_hi_n,
    output logic              ext_oe_lo_n,
    output logic              ext_we_hi_n,
    output logic              ext_we_lo_n
);

    acc_kind_e         kind;
    logic              rd_req, wr_req;
    logic              attr_ok, attr_wr_any;
    logic [LANE_W-1:0] attr_rd;

    card_access_decode u_decode (
        .ce1_n  (ce1_n),
        .ce2_n  (ce2_n),
        .a0     (host_addr[0]),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .kind   (kind),
        .rd_req (rd_req),
        .wr_req (wr_req)
    );

    // Attribute space answers only even single-byte accesses
    assign attr_ok     = !reg_n && (kind == ACC_EVEN);
    assign attr_wr_any = attr_ok && wr_req;

    card_attr_store #(
        .DEPTH  (ATTR_DEPTH),
        .LANE_W (LANE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_any  (attr_wr_any),
        .wp      (wp),
        .idx     (host_addr[WIN_W-1:1]),
        .wdata   (hd_in[LANE_W-1:0]),
        .rd_data (attr_rd)
    );

    card_lane_steer #(
        .LANE_W (LANE_W)
    ) u_steer (
        .kind        (kind),
        .common_sel  (reg_n),
        .attr_ok     (attr_ok),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .wp          (wp),
        .hd_in       (hd_in),
        .id_in       (id_in),
        .attr_rd     (attr_rd),
        .hd_out      (hd_out),
        .hd_drv_hi   (hd_drv_hi),
        .hd_drv_lo   (hd_drv_lo),
        .id_out      (id_out),
        .id_drv_hi   (id_drv_hi),
        .id_drv_lo   (id_drv_lo),
        .ext_oe_hi_n (ext_oe_hi_n),
        .ext_oe_lo_n (ext_oe_lo_n),
        .ext_we_hi_n (ext_we_hi_n),
        .ext_we_lo_n (ext_we_lo_n)
    );

    assign ext_addr = host_addr[ADDR_W-1:WIN_W];

    // R10
    wp_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> (ext_we_hi_n && ext_we_lo_n));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n) |-> (ext_oe_hi_n && ext_oe_lo_n && ext_we_hi_n && ext_we_lo_n
                              && !hd_drv_hi && !hd_drv_lo && !id_drv_hi && !id_drv_lo));

    // R9
    attr_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_n |-> (ext_oe_hi_n && ext_oe_lo_n && ext_we_hi_n && ext_we_lo_n
                    && !id_drv_hi && !id_drv_lo));

    // R8
    attr_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_n |-> !hd_drv_hi);

    // R12
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((hd_drv_hi || hd_drv_lo) && (id_drv_hi || id_drv_lo)));

endmodule

// File: tb/card_lane_ctrl_tb.sv
`timescale 1ns/1ps
module card_lane_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
    logic [24:0] host_addr = '0;
    logic [15:0] hd_in = '0, id_in = '0;
    logic [15:0] hd_out, id_out, ext_addr;
    logic        hd_drv_hi, hd_drv_lo, id_drv_hi, id_drv_lo;
    logic        ext_oe_hi_n, ext_oe_lo_n, ext_we_hi_n, ext_we_lo_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    card_lane_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
        .oe_n(oe_n), .we_n(we_n), .wp(wp), .host_addr(host_addr), .hd_in(hd_in),
        .hd_out(hd_out), .hd_drv_hi(hd_drv_hi), .hd_drv_lo(hd_drv_lo),
        .id_in(id_in), .id_out(id_out), .id_drv_hi(id_drv_hi), .id_drv_lo(id_drv_lo),
        .ext_addr(ext_addr), .ext_oe_hi_n(ext_oe_hi_n), .ext_oe_lo_n(ext_oe_lo_n),
        .ext_we_hi_n(ext_we_hi_n), .ext_we_lo_n(ext_we_lo_n)
    );

    // {hd_drv_hi, hd_drv_lo, hd_out, id_drv_hi, id_drv_lo, id_out, oe_hi_n, oe_lo_n, we_hi_n, we_lo_n}
    wire [39:0] obs = {hd_drv_hi, hd_drv_lo, hd_out, id_drv_hi, id_drv_lo, id_out,
                       ext_oe_hi_n, ext_oe_lo_n, ext_we_hi_n, ext_we_lo_n};

    function automatic logic [39:0] pack(logic [1:0] hdrv, logic [15:0] hd,
                                         logic [1:0] idrv, logic [15:0] id, logic [3:0] stb);
        return {hdrv, hd, idrv, id, stb};
    endfunction

    localparam logic [39:0] QUIET = {2'b00, 16'h0, 2'b00, 16'h0, 4'b1111};

    task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic c1, logic c2, logic rg, logic oe, logic we, logic p,
                         logic [24:0] a, logic [15:0] hdi, logic [15:0] idi);
        @(negedge clk);
        ce1_n = c1; ce2_n = c2; reg_n = rg; oe_n = oe; we_n = we; wp = p;
        host_addr = a; hd_in = hdi; id_in = idi;
        #1;
    endtask

    task automatic go_idle();
        drive(1, 1, 1, 1, 1, 0, 25'h0, 16'h0, 16'h0);
    endtask

    task automatic attr_write(logic [7:0] idx, logic [7:0] d, logic p);
        drive(0, 1, 0, 1, 0, p, {16'h0, idx, 1'b0}, {8'hFF, d}, 16'h0);
        // R9: attribute write raises no external strobe and drives no bus
        check("R9 attr write quiet", obs, QUIET);
        go_idle();
        @(posedge clk);
    endtask

    task automatic attr_read_check(string tag, logic [7:0] idx, logic [7:0] exp, logic p);
        drive(0, 1, 0, 0, 1, p, {16'h0, idx, 1'b0}, 16'hFFFF, 16'hFFFF);
        check(tag, obs, pack(2'b01, {8'h00, exp}, 2'b00, 16'h0, 4'b1111));
    endtask

    task automatic t_reset();
        go_idle();
        check("R6 idle after reset", obs, QUIET);
        attr_read_check("R1 attr zero after reset", 8'h08, 8'h00, 0);
        attr_read_check("R1 attr zero top index", 8'hFF, 8'h00, 0);
    endtask

    task automatic t_even();
        drive(0, 1, 1, 0, 1, 0, 25'h100, 16'h0, 16'hA55A);
        check("R2 even read", obs, pack(2'b01, 16'h005A, 2'b00, 16'h0, 4'b1011));
        drive(0, 1, 1, 1, 0, 0, 25'h100, 16'h1234, 16'h0);
        check("R2 even write", obs, pack(2'b00, 16'h0, 2'b01, 16'h0034, 4'b1110));
    endtask

    task automatic t_odd_swap();
        drive(0, 1, 1, 0, 1, 0, 25'h101, 16'h0, 16'hA55A);
        check("R3 odd swap read", obs, pack(2'b01, 16'h00A5, 2'b00, 16'h0, 4'b0111));
        drive(0, 1, 1, 1, 0, 0, 25'h101, 16'h1234, 16'h0);
        check("R3 odd swap write", obs, pack(2'b00, 16'h0, 2'b10, 16'h3400, 4'b1101));
    endtask

    task automatic t_odd_only();
        drive(1, 0, 1, 0, 1, 0, 25'h101, 16'h0, 16'hA55A);
        check("R4 odd only read", obs, pack(2'b10, 16'hA500, 2'b00, 16'h0, 4'b0111));
        drive(1, 0, 1, 1, 0, 0, 25'h101, 16'h1234, 16'h0);
        check("R4 odd only write", obs, pack(2'b00, 16'h0, 2'b10, 16'h1200, 4'b1101));
    endtask

    task automatic t_word();
        drive(0, 0, 1, 0, 1, 0, 25'h200, 16'h0, 16'hA55A);
        check("R5 word read", obs, pack(2'b11, 16'hA55A, 2'b00, 16'h0, 4'b0011));
        drive(0, 0, 1, 1, 0, 0, 25'h200, 16'h1234, 16'h0);
        check("R5 word write", obs, pack(2'b00, 16'h0, 2'b11, 16'h1234, 4'b1100));
    endtask

    task automatic t_idle();
        drive(1, 1, 1, 0, 1, 0, 25'h0, 16'hFFFF, 16'hFFFF);
        check("R6 both enables high read", obs, QUIET);
        drive(1, 1, 1, 1, 0, 0, 25'h0, 16'hFFFF, 16'hFFFF);
        check("R6 both enables high write", obs, QUIET);
        drive(0, 0, 1, 1, 1, 0, 25'h0, 16'hFFFF, 16'hFFFF);
        check("R6 enabled without strobe", obs, QUIET);
    endtask

    task automatic t_attr();
        attr_write(8'h05, 8'hC3, 0);
        attr_read_check("R8 attr read idx5", 8'h05, 8'hC3, 0);
        // R7: data changes while the strobe is held do not re-commit
        drive(0, 1, 0, 1, 0, 0, 25'h0C, 16'h003C, 16'h0);
        drive(0, 1, 0, 1, 0, 0, 25'h0C, 16'h0077, 16'h0);
        drive(0, 1, 0, 1, 0, 0, 25'h0C, 16'h0088, 16'h0);
        go_idle();
        @(posedge clk);
        attr_read_check("R7 held strobe commits once", 8'h06, 8'h3C, 0);
        attr_read_check("R7 index from addr bits 8:1", 8'h05, 8'hC3, 0);
    endtask

    task automatic t_unsupported();
        drive(0, 0, 0, 0, 1, 0, 25'h0A, 16'h0, 16'hFFFF);
        check("R9 attr word read", obs, QUIET);
        drive(1, 0, 0, 0, 1, 0, 25'h0A, 16'h0, 16'hFFFF);
        check("R9 attr odd only read", obs, QUIET);
        drive(0, 1, 0, 0, 1, 0, 25'h0B, 16'h0, 16'hFFFF);
        check("R9 attr odd address read", obs, QUIET);
        drive(0, 1, 0, 1, 0, 0, 25'h0B, 16'h0099, 16'h0);
        check("R9 attr odd address write", obs, QUIET);
        @(posedge clk);
        drive(0, 0, 0, 1, 0, 0, 25'h0A, 16'h5555, 16'h0);
        check("R9 attr word write", obs, QUIET);
        @(posedge clk);
        go_idle();
        @(posedge clk);
        attr_read_check("R9 store unchanged", 8'h05, 8'hC3, 0);
    endtask

    task automatic t_wp();
        drive(0, 0, 1, 1, 0, 1, 25'h200, 16'h1234, 16'h0);
        check("R10 wp word write", obs, pack(2'b00, 16'h0, 2'b11, 16'h1234, 4'b1111));
        drive(0, 1, 1, 1, 0, 1, 25'h101, 16'h1234, 16'h0);
        check("R10 wp swap write", obs, pack(2'b00, 16'h0, 2'b10, 16'h3400, 4'b1111));
        drive(0, 0, 1, 0, 1, 1, 25'h200, 16'h0, 16'hBEEF);
        check("R10 wp common read", obs, pack(2'b11, 16'hBEEF, 2'b00, 16'h0, 4'b0011));
        attr_write(8'h05, 8'h11, 1);
        attr_read_check("R10 wp attr write blocked", 8'h05, 8'hC3, 1);
    endtask

    task automatic t_addr();
        drive(1, 1, 1, 1, 1, 0, 25'h1ABCDE0, 16'h0, 16'h0);
        checks++;
        if (ext_addr !== 16'hD5E6) begin
            fails++;
            $display("FAIL R11 addr pass actual=%h expected=%h", ext_addr, 16'hD5E6);
        end
        drive(0, 0, 0, 0, 1, 0, 25'h0FF01FF, 16'h0, 16'h0);
        checks++;
        if (ext_addr !== 16'h7F80) begin
            fails++;
            $display("FAIL R11 addr pass actual=%h expected=%h", ext_addr, 16'h7F80);
        end
    endtask

    task automatic t_prio();
        drive(0, 1, 1, 0, 0, 0, 25'h100, 16'h00AB, 16'hFFFF);
        check("R12 write wins over oe", obs, pack(2'b00, 16'h0, 2'b01, 16'h00AB, 4'b1110));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_even();
        t_odd_swap();
        t_odd_only();
        t_word();
        t_idle();
        t_attr();
        t_unsupported();
        t_wp();
        t_addr();
        t_prio();
        go_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule